// File: doc/BRIEF.md
# Staggered Column Power Sequencer

This block produces the digital control sequence that moves the analog front-ends of a pixel matrix between full power and a saving state, one column at a time. A synchronous external enable starts each ramp. Columns then change state one after another, with a programmable number of clock cycles between neighbours, so that the supply current rises and falls in steps rather than all at once. Power-down walks the columns in the same ascending order as power-up. If the enable changes while a ramp is still running, the ramp turns back and starts from the column that changed last.

Each column has two controls. The first picks nominal or low-power bias. The second is an optional deeper level that cuts the column's analog supply. The deep level is applied only after a column has rested in low-power bias for one full stagger interval. It is released one interval before that column is due back at nominal bias. A ready flag tells the acquisition logic that every column is on and that a programmable settling time has elapsed. Acquisition must not start before this flag is set.

Top module: `col_power_seq`

## Requirements
- R1: While reset is active and directly after it, every column is at low-power bias (`col_bias_nom` all 0), `col_analog_off` is all 0 and `all_on` is 0.
- R2: With S = max(`stagger_cfg`, 1), suppose `pwr_en` is first seen high at clock edge P while all columns are idle. Column k (k = 0 is bit 0) then shows nominal bias from edge P+(k+1)·S onward. Columns come on in ascending index order.
- R3: A `stagger_cfg` value of 0 acts as 1, so the columns change one per cycle.
- R4: From the fully-on state, suppose `pwr_en` is first seen low at edge P. Column k then returns to low-power bias at edge P+(k+1)·S. Power-down uses the same ascending order as power-up.
- R5: Suppose `pwr_en` changes at edge Q while a ramp is unfinished. One interval later, at edge Q+S, the ramp reverses: the column changed last changes back first, and the others follow every S cycles in descending order.
- R6: At most one column changes bias per clock cycle, and two column changes are always at least S cycles apart.
- R7: When `deep_off_en` is 1, `col_analog_off[i]` rises exactly S cycles after column i entered low-power bias (or after reset). It is never 1 while column i is at nominal bias.
- R8: `col_analog_off` of the next column due to power up falls S cycles before its bias returns to nominal. For the first column this is at the edge that first sees `pwr_en` high. When `deep_off_en` is 0, `col_analog_off` stays all 0.
- R9: `all_on` rises `settle_cfg` cycles after the edge at which the last column reaches nominal bias. It falls at the edge that first sees `pwr_en` low. It is never 1 unless every column is at nominal bias.
- R10: The set of columns at nominal bias is always one contiguous run of indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Synchronous power request; 1 ramps the columns on, 0 ramps them off |
| stagger_cfg | input | STG_W | Cycles between adjacent column changes (0 acts as 1) |
| settle_cfg | input | SET_W | Settling cycles after the last column before `all_on` |
| deep_off_en | input | 1 | Permits cutting the analog supply of resting columns |
| col_bias_nom | output | N_COLS | Per column: 1 = nominal bias, 0 = low-power bias |
| col_analog_off | output | N_COLS | Per column: 1 = analog supply cut |
| all_on | output | 1 | Every column on and settled; acquisition may start |

## Verification
Two functions can act on the same column in the same cycle. One is the step that brings a column to nominal bias. The other is the release of the deep-off level of the column after it. The bench runs a full ramp with deep-off enabled and checks, at every cycle, that the supply cut is lifted for exactly the next pending column while the one before it turns on. A direction reversal while a ramp is in progress is also provoked in both directions. That case tests whether the reload of the interval timer and a pending step could collide: each cycle of the reversed ramp is compared against the descending column order expected from the edge at which the enable changed.

// File: rtl/pps_pkg.sv
package pps_pkg;

    // Kind of column move taken by the ramp controller in one cycle.
    // The on-set is the index range [lo, hi).
    typedef enum logic [2:0] {
        STEP_NONE   = 3'd0,
        STEP_HI_INC = 3'd1,  // forward power-up: next column above comes on
        STEP_LO_INC = 3'd2,  // forward power-down: lowest on column goes off
        STEP_HI_DEC = 3'd3,  // reversed power-up: highest on column goes off
        STEP_LO_DEC = 3'd4   // reversed power-down: column below comes back on
    } step_e;

endpackage

// File: rtl/pps_ramp_ctrl.sv
module pps_ramp_ctrl
    import pps_pkg::*;
#(
    parameter int N_COLS = 16,
    parameter int STG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [STG_W-1:0]  stg_eff,
    output logic [N_COLS-1:0] bias_q,
    output logic [N_COLS-1:0] bias_d,
    output logic [N_COLS-1:0] wake_d,
    output logic              full_d,
    output logic              en_d
);

    localparam int CW = $clog2(N_COLS + 1);
    localparam logic [CW-1:0] LAST = CW'(N_COLS);

    typedef struct packed {
        logic              en;
        logic [CW-1:0]     lo;
        logic [CW-1:0]     hi;
        logic [STG_W-1:0]  tmr;
        logic [STG_W:0]    gap;
        logic [N_COLS-1:0] mask;
    } ctl_t;

    ctl_t          cur_q;
    ctl_t          nxt_d;
    logic          stepping;
    step_e         kind;
    logic          full_q;
    logic          empty_q;
    logic          busy;
    logic [CW-1:0] next_up;

    always_comb begin
        nxt_d    = cur_q;
        stepping = 1'b0;
        kind     = STEP_NONE;
        nxt_d.en = pwr_en;
        full_q   = (cur_q.lo == '0) && (cur_q.hi == LAST);
        empty_q  = (cur_q.lo == cur_q.hi);
        busy     = cur_q.en ? !full_q : !empty_q;

        if (pwr_en != cur_q.en) begin
            // direction change: wait one interval before the first move
            nxt_d.tmr = stg_eff - 1'b1;
        end else if (busy) begin
            if (cur_q.tmr == '0) begin
                stepping  = 1'b1;
                nxt_d.tmr = stg_eff - 1'b1;
                if (cur_q.en) begin
                    kind = (cur_q.lo != '0) ? STEP_LO_DEC : STEP_HI_INC;
                end else begin
                    kind = ((cur_q.lo == '0) && (cur_q.hi != LAST)) ? STEP_HI_DEC : STEP_LO_INC;
                end
            end else begin
                nxt_d.tmr = cur_q.tmr - 1'b1;
            end
        end

        case (kind)
            STEP_HI_INC: nxt_d.hi = cur_q.hi + 1'b1;
            STEP_HI_DEC: nxt_d.hi = cur_q.hi - 1'b1;
            STEP_LO_INC: nxt_d.lo = cur_q.lo + 1'b1;
            STEP_LO_DEC: nxt_d.lo = cur_q.lo - 1'b1;
            default: ;
        endcase

        if (nxt_d.lo == nxt_d.hi) begin
            nxt_d.lo = '0;
            nxt_d.hi = '0;
        end

        if (stepping) begin
            nxt_d.gap = {{STG_W{1'b0}}, 1'b1};
        end else if (cur_q.gap != '1) begin
            nxt_d.gap = cur_q.gap + 1'b1;
        end

        for (int i = 0; i < N_COLS; i++) begin
            nxt_d.mask[i] = (CW'(i) >= nxt_d.lo) && (CW'(i) < nxt_d.hi);
        end

        full_d  = (nxt_d.lo == '0) && (nxt_d.hi == LAST);
        next_up = (nxt_d.lo != '0) ? (nxt_d.lo - 1'b1) : nxt_d.hi;
        for (int i = 0; i < N_COLS; i++) begin
            wake_d[i] = nxt_d.en && !full_d && (CW'(i) == next_up);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{en: 1'b0, lo: '0, hi: '0, tmr: '0, gap: '1, mask: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bias_q = cur_q.mask;
    assign bias_d = nxt_d.mask;
    assign en_d   = nxt_d.en;

    AST_STAGGER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |-> (cur_q.gap >= {1'b0, stg_eff})) else $error("column moves closer than one interval"); // R6

    AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({1'b0, bias_q} ^ {bias_q, 1'b0}) <= 2) else $error("on-set not contiguous"); // R10

endmodule

// File: rtl/pps_col_slot.sv
module pps_col_slot #(
    parameter int STG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STG_W-1:0] stg_eff,
    input  logic             deep_en,
    input  logic             bias_q,
    input  logic             bias_d,
    input  logic             wake_d,
    output logic             off_q
);

    typedef struct packed {
        logic [STG_W-1:0] age;
        logic             off;
    } slot_t;

    slot_t cur_q;
    slot_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (bias_d || wake_d || bias_q) begin
            nxt_d.age = '0;
        end else if (cur_q.age < stg_eff) begin
            nxt_d.age = cur_q.age + 1'b1;
        end
        nxt_d.off = deep_en && !bias_d && !wake_d && (nxt_d.age >= stg_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{age: '0, off: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign off_q = cur_q.off;

    AST_CUT_ONLY_AT_LOW_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> !bias_q) else $error("supply cut while at nominal bias"); // R7

    AST_SUPPLY_BEFORE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_q) |-> !$past(off_q)) else $error("bias returned before supply"); // R8

endmodule

// File: rtl/pps_settle.sv
module pps_settle #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] settle_cfg,
    input  logic             full_d,
    input  logic             en_d,
    output logic             all_on_q
);

    typedef struct packed {
        logic [SET_W-1:0] cnt;
        logic             full;
        logic             on;
    } settle_t;

    settle_t cur_q;
    settle_t nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.full = full_d && en_d;
        if (!nxt_d.full || !cur_q.full) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt < settle_cfg) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        nxt_d.on = nxt_d.full && (nxt_d.cnt >= settle_cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cnt: '0, full: 1'b0, on: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign all_on_q = cur_q.on;

endmodule

// File: rtl/col_power_seq.sv
module col_power_seq #(
    parameter int N_COLS = 16,
    parameter int STG_W  = 8,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [STG_W-1:0]  stagger_cfg,
    input  logic [SET_W-1:0]  settle_cfg,
    input  logic              deep_off_en,
    output logic [N_COLS-1:0] col_bias_nom,
    output logic [N_COLS-1:0] col_analog_off,
    output logic              all_on
);

    logic [STG_W-1:0]  stg_eff;
    logic [N_COLS-1:0] bias_q;
    logic [N_COLS-1:0] bias_d;
    logic [N_COLS-1:0] wake_d;
    logic              full_d;
    logic              en_d;

    assign stg_eff = (stagger_cfg == '0) ? {{(STG_W-1){1'b0}}, 1'b1} : stagger_cfg;

    pps_ramp_ctrl #(.N_COLS(N_COLS), .STG_W(STG_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_en  (pwr_en),
        .stg_eff (stg_eff),
        .bias_q  (bias_q),
        .bias_d  (bias_d),
        .wake_d  (wake_d),
        .full_d  (full_d),
        .en_d    (en_d)
    );

    for (genvar g = 0; g < N_COLS; g++) begin : g_col
        pps_col_slot #(.STG_W(STG_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .stg_eff (stg_eff),
            .deep_en (deep_off_en),
            .bias_q  (bias_q[g]),
            .bias_d  (bias_d[g]),
            .wake_d  (wake_d[g]),
            .off_q   (col_analog_off[g])
        );
    end

    pps_settle #(.SET_W(SET_W)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .settle_cfg (settle_cfg),
        .full_d     (full_d),
        .en_d       (en_d),
        .all_on_q   (all_on)
    );

    assign col_bias_nom = bias_q;

    AST_ONE_COLUMN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_bias_nom ^ $past(col_bias_nom)) <= 1) else $error("several columns moved"); // R6

    AST_READY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        all_on |-> (&col_bias_nom)) else $error("ready flag with a column down"); // R9

endmodule

// File: tb/test_col_power_seq.sv
module test_col_power_seq;

    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_en = 1'b0;
    logic [7:0]    stagger_cfg = 8'd3;
    logic [7:0]    settle_cfg = 8'd0;
    logic          deep_off_en = 1'b0;
    logic [NC-1:0] col_bias_nom;
    logic [NC-1:0] col_analog_off;
    logic          all_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    col_power_seq i_col_power_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_en         (pwr_en),
        .stagger_cfg    (stagger_cfg),
        .settle_cfg     (settle_cfg),
        .deep_off_en    (deep_off_en),
        .col_bias_nom   (col_bias_nom),
        .col_analog_off (col_analog_off),
        .all_on         (all_on)
    );

    function automatic logic [NC-1:0] low_ones(int k);
        logic [NC-1:0] r;
        for (int i = 0; i < NC; i++) r[i] = (i < k);
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step_sample();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step_sample();
    endtask

    task automatic t_reset();
        check(col_bias_nom == '0, "R1 bias", 64'(col_bias_nom), 64'd0);
        check(col_analog_off == '0, "R1 cut", 64'(col_analog_off), 64'd0);
        check(all_on == 1'b0, "R1 ready", 64'(all_on), 64'd0);
    endtask

    task automatic run_up(int s, int t, string req);
        int se = (s == 0) ? 1 : s;
        stagger_cfg = 8'(s);
        settle_cfg  = 8'(t);
        pwr_en = 1'b1;
        for (int c = 0; c <= NC*se + t + 2; c++) begin
            step_sample();
            check(col_bias_nom == low_ones(c / se), req, 64'(col_bias_nom), 64'(low_ones(c / se)));
            check(all_on == (c >= NC*se + t), "R9 settle", 64'(all_on), 64'(c >= NC*se + t));
        end
    endtask

    task automatic run_down(int s, string req);
        int se = (s == 0) ? 1 : s;
        stagger_cfg = 8'(s);
        pwr_en = 1'b0;
        for (int c = 0; c <= NC*se + 2; c++) begin
            step_sample();
            check(col_bias_nom == ~low_ones(c / se), req, 64'(col_bias_nom), 64'(~low_ones(c / se)));
            check(all_on == 1'b0, "R9 drop", 64'(all_on), 64'd0);
        end
    endtask

    task automatic t_reverse_up();
        int n;
        stagger_cfg = 8'd4;
        pwr_en = 1'b1;
        for (int c = 0; c <= 13; c++) begin
            step_sample();
            check(col_bias_nom == low_ones(c / 4), "R5 pre", 64'(col_bias_nom), 64'(low_ones(c / 4)));
        end
        pwr_en = 1'b0;
        for (int c = 0; c <= 14; c++) begin
            step_sample();
            n = 3 - c / 4;
            if (n < 0) n = 0;
            check(col_bias_nom == low_ones(n), "R5 up reversed", 64'(col_bias_nom), 64'(low_ones(n)));
        end
    endtask

    task automatic t_reverse_down();
        int lo;
        run_up(4, 2, "R2 stagger 4");
        pwr_en = 1'b0;
        for (int c = 0; c <= 9; c++) begin
            step_sample();
            check(col_bias_nom == ~low_ones(c / 4), "R4 pre", 64'(col_bias_nom), 64'(~low_ones(c / 4)));
        end
        pwr_en = 1'b1;
        for (int c = 0; c <= 12; c++) begin
            step_sample();
            lo = 2 - c / 4;
            if (lo < 0) lo = 0;
            check(col_bias_nom == ~low_ones(lo), "R5 down reversed", 64'(col_bias_nom), 64'(~low_ones(lo)));
            check(all_on == (c >= 10), "R9 after reversal", 64'(all_on), 64'(c >= 10));
        end
        run_down(4, "R4 stagger 4");
    endtask

    task automatic t_deep_off();
        int k;
        logic [NC-1:0] exp;
        stagger_cfg = 8'd3;
        deep_off_en = 1'b1;
        idle(20);
        check(col_analog_off == '1, "R7 idle cut", 64'(col_analog_off), 64'(low_ones(NC)));
        pwr_en = 1'b1;
        for (int c = 0; c <= NC*3 + 1; c++) begin
            step_sample();
            k = c / 3 + 1;
            if (k > NC) k = NC;
            exp = ~low_ones(k);
            check(col_analog_off == exp, "R8 release lead", 64'(col_analog_off), 64'(exp));
            check(col_bias_nom == low_ones(c / 3), "R2 with cut", 64'(col_bias_nom), 64'(low_ones(c / 3)));
        end
        pwr_en = 1'b0;
        for (int c = 0; c <= (NC + 2)*3 + 1; c++) begin
            step_sample();
            for (int i = 0; i < NC; i++) exp[i] = (c >= (i + 2)*3);
            check(col_analog_off == exp, "R7 cut delay", 64'(col_analog_off), 64'(exp));
        end
    endtask

    task automatic t_deep_disabled();
        deep_off_en = 1'b0;
        step_sample();
        check(col_analog_off == '0, "R8 disabled", 64'(col_analog_off), 64'd0);
        idle(10);
        check(col_analog_off == '0, "R8 disabled idle", 64'(col_analog_off), 64'd0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        idle(4);
        run_up(3, 5, "R2 ascending");
        run_down(3, "R4 same order");
        idle(4);
        run_up(0, 0, "R3 zero stagger");
        run_down(0, "R3 zero stagger down");
        idle(4);
        t_reverse_up();
        idle(4);
        t_reverse_down();
        idle(4);
        t_deep_off();
        t_deep_disabled();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule